// File: doc/BRIEF.md
# Randomized Retry Controller for a Paired Network Output

This block is one half of a pair of identical transmit-side controllers that behave, from the software view, as a single network output. Both halves receive every operation start at the same moment. Each half XORs two shared random bits and compares the result with its own unit identifier. Only the half that matches takes the attempt, so exactly one of the pair transmits.

A connection attempt can fail. When that happens and retries remain, the owning half pulses its retransmit output. The two outputs are ORed into one shared line. On that pulse both halves step their retry counters and their status pointers, so the two copies stay equal without any central arbiter. On the next cycle both halves draw the random bits again to pick the owner of the next attempt.

The owner logs one 64-bit status record per attempt at the current pointer. It always logs a failed attempt. It logs a successful open only when that option is enabled. When the attempts run out, or when the connection opens, the owner reports the outcome through an acknowledge pair. An abort during transmission drops the connection at once.

Top module: `rrc_unit`

## Requirements
- R1: After reset the unit is idle: tx_active, retx_out, drop_out, st_wr_req, ack_seen and ack_good are 0, and retry_cnt is 0.
- R2: When op_start is sampled high, the unit has tx_active high from the next cycle if and only if rnd_a XOR rnd_b equals UNIT_ID. In a pair with UNIT_ID 0 and 1, exactly one unit transmits.
- R3: When the owner samples conn_done high with conn_ok low and retry_cnt below the latched limit, it drives retx_out high for exactly the following cycle and drops tx_active. The non-owner never drives retx_out.
- R4: On every cycle in which retx_in is high while an operation is pending, both units increment retry_cnt and advance their status pointer by one. The two retry counts therefore stay equal.
- R5: On the cycle after retx_in is seen, each unit samples rnd_a XOR rnd_b again. The unit that matches has tx_active high from the cycle after that.
- R6: A failure sampled when retry_cnt equals the limit latched at start (cfg_retries) produces no retransmit pulse. It sets ack_seen to 1 and ack_good to 0, and the unit goes idle. A limit of N therefore allows N+1 attempts.
- R7: Each failed attempt raises st_wr_req for one cycle, the cycle after conn_done. st_wr_addr is the start pointer plus the attempt index. st_wr_data has bit 0 = outcome (1 success), bit 1 = UNIT_ID, bits [8+RETRY_W-1:8] = attempt index, and all other bits 0.
- R8: A successful attempt sets ack_seen and ack_good to 1 and clears tx_active. It writes a record (format as R7, bit 0 set) only if cfg_log_ok was high at start.
- R9: op_abort sampled while transmitting raises drop_out for one cycle and clears tx_active. op_abort in any other state returns the unit to idle without drop_out.
- R10: op_start clears ack_seen and ack_good, loads retry_cnt with 0 and loads the status pointer from cfg_status_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle strobe: new operation issued |
| op_abort | input | 1 | One-cycle strobe: abandon the current operation |
| cfg_retries | input | RETRY_W | Retransmission limit, latched at start |
| cfg_log_ok | input | 1 | Also log successful opens, latched at start |
| cfg_status_base | input | PTR_W | Start address of the status record area |
| rnd_a | input | 1 | First shared random bit |
| rnd_b | input | 1 | Second shared random bit |
| retx_in | input | 1 | Shared retransmit line (OR of both units' retx_out) |
| retx_out | output | 1 | This unit's retransmit request |
| conn_done | input | 1 | Attempt outcome valid (owner only) |
| conn_ok | input | 1 | Attempt outcome: 1 opened, 0 failed |
| tx_active | output | 1 | Unit owns and is running the current attempt |
| drop_out | output | 1 | One-cycle request to send a drop |
| st_wr_req | output | 1 | Status record write strobe |
| st_wr_addr | output | PTR_W | Status record address |
| st_wr_data | output | 64 | Status record |
| retry_cnt | output | RETRY_W | Retransmissions so far in this operation |
| ack_seen | output | 1 | Final outcome known |
| ack_good | output | 1 | Final outcome was success (valid with ack_seen) |

## Verification
The hardest case to reach is a hand-over: one unit fails, and the other unit wins the next draw. That unit must then log at the pointer it advanced only by watching the shared line. The bench runs two units side by side with their retransmit outputs ORed. It draws fresh random bits before every selection edge and injects a random mix of outcomes, so owners alternate often. Directed operations add a zero limit, a run of failures up to the limit, success logging turned on and off, and an abort in mid-transmission.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
   localparam int unsigned REC_W = 64;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OWN  = 2'd1,
      ST_PEER = 2'd2,
      ST_PICK = 2'd3
   } rrc_state_e;

   // status record: bit0 outcome, bit1 unit, attempt index from bit 8 upward
   function automatic logic [REC_W-1:0] pack_record(input logic ok, input logic unit,
                                                    input logic [55:0] attempt);
      logic [REC_W-1:0] r;
      r = '0;
      r[0] = ok;
      r[1] = unit;
      r[REC_W-1:8] = attempt;
      return r;
   endfunction
endpackage

// File: rtl/rrc_pick.sv
module rrc_pick #(
   parameter bit UNIT_ID = 1'b0
) (
   input  logic rnd_a,
   input  logic rnd_b,
   output logic mine
);
   assign mine = ((rnd_a ^ rnd_b) == UNIT_ID);
endmodule

// File: rtl/rrc_log.sv
module rrc_log
   import rrc_pkg::*;
#(
   parameter int unsigned PTR_W   = 16,
   parameter int unsigned RETRY_W = 4,
   parameter bit          UNIT_ID = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PTR_W-1:0]   base,
   input  logic               step,
   input  logic               emit,
   input  logic               ok,
   input  logic [RETRY_W-1:0] attempt,
   output logic               wr_req,
   output logic [PTR_W-1:0]   wr_addr,
   output logic [REC_W-1:0]   wr_data
);
   localparam int unsigned PAD_W = 56 - RETRY_W;

   logic [PTR_W-1:0] ptr_q;
   logic [55:0]      attempt_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign attempt_ext = {{PAD_W{1'b0}}, attempt};
      end else begin : g_nopad
         assign attempt_ext = attempt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         wr_req  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_req <= 1'b0;
         if (load) begin
            ptr_q <= base;
         end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
         end
         if (emit) begin
            wr_req  <= 1'b1;
            wr_addr <= ptr_q;
            wr_data <= pack_record(ok, UNIT_ID, attempt_ext);
         end
      end
   end
endmodule

// File: rtl/rrc_unit.sv
module rrc_unit
   import rrc_pkg::*;
#(
   parameter bit          UNIT_ID = 1'b0,
   parameter int unsigned RETRY_W = 4,
   parameter int unsigned PTR_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_start,
   input  logic               op_abort,
   input  logic [RETRY_W-1:0] cfg_retries,
   input  logic               cfg_log_ok,
   input  logic [PTR_W-1:0]   cfg_status_base,
   input  logic               rnd_a,
   input  logic               rnd_b,
   input  logic               retx_in,
   output logic               retx_out,
   input  logic               conn_done,
   input  logic               conn_ok,
   output logic               tx_active,
   output logic               drop_out,
   output logic               st_wr_req,
   output logic [PTR_W-1:0]   st_wr_addr,
   output logic [REC_W-1:0]   st_wr_data,
   output logic [RETRY_W-1:0] retry_cnt,
   output logic               ack_seen,
   output logic               ack_good
);
   if (RETRY_W < 1 || RETRY_W > 56) begin : g_bad_retry_w
      $error("rrc_unit: RETRY_W must lie in 1..56");
   end
   if (PTR_W < 2) begin : g_bad_ptr_w
      $error("rrc_unit: PTR_W must be at least 2");
   end

   rrc_state_e         state_q;
   logic [RETRY_W-1:0] cnt_q;
   logic [RETRY_W-1:0] limit_q;
   logic               log_ok_q;
   logic               retx_q;
   logic               drop_q;
   logic               seen_q;
   logic               good_q;
   logic               mine;
   logic               owner_result;
   logic               emit;
   logic               step;

   rrc_pick #(.UNIT_ID(UNIT_ID)) u_pick (
      .rnd_a (rnd_a),
      .rnd_b (rnd_b),
      .mine  (mine)
   );

   assign owner_result = (state_q == ST_OWN) && conn_done && !op_abort && !op_start;
   assign emit         = owner_result && (!conn_ok || log_ok_q);
   assign step         = (state_q == ST_PEER) && retx_in && !op_abort && !op_start;

   rrc_log #(.PTR_W(PTR_W), .RETRY_W(RETRY_W), .UNIT_ID(UNIT_ID)) u_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (op_start),
      .base    (cfg_status_base),
      .step    (step),
      .emit    (emit),
      .ok      (conn_ok),
      .attempt (cnt_q),
      .wr_req  (st_wr_req),
      .wr_addr (st_wr_addr),
      .wr_data (st_wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         limit_q  <= '0;
         log_ok_q <= 1'b0;
         retx_q   <= 1'b0;
         drop_q   <= 1'b0;
         seen_q   <= 1'b0;
         good_q   <= 1'b0;
      end else begin
         retx_q <= 1'b0;
         drop_q <= 1'b0;
         if (op_start) begin
            cnt_q    <= '0;
            limit_q  <= cfg_retries;
            log_ok_q <= cfg_log_ok;
            seen_q   <= 1'b0;
            good_q   <= 1'b0;
            state_q  <= mine ? ST_OWN : ST_PEER;
         end else begin
            unique case (state_q)
               ST_OWN: begin
                  if (op_abort) begin
                     drop_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (conn_done) begin
                     if (conn_ok) begin
                        seen_q  <= 1'b1;
                        good_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end else if (cnt_q == limit_q) begin
                        seen_q  <= 1'b1;
                        good_q  <= 1'b0;
                        state_q <= ST_IDLE;
                     end else begin
                        retx_q  <= 1'b1;
                        state_q <= ST_PEER;
                     end
                  end
               end
               ST_PEER: begin
                  if (op_abort) begin
                     state_q <= ST_IDLE;
                  end else if (retx_in) begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_PICK;
                  end
               end
               ST_PICK: begin
                  if (op_abort) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= mine ? ST_OWN : ST_PEER;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign tx_active = (state_q == ST_OWN);
   assign retx_out  = retx_q;
   assign drop_out  = drop_q;
   assign retry_cnt = cnt_q;
   assign ack_seen  = seen_q;
   assign ack_good  = good_q;
endmodule

// File: rtl/rrc_unit_chk.sv
module rrc_unit_chk #(
   parameter bit          UNIT_ID = 1'b0,
   parameter int unsigned RETRY_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_start,
   input logic               op_abort,
   input logic               rnd_a,
   input logic               rnd_b,
   input logic               retx_in,
   input logic               retx_out,
   input logic               conn_done,
   input logic               conn_ok,
   input logic               tx_active,
   input logic               drop_out,
   input logic               st_wr_req,
   input logic [RETRY_W-1:0] retry_cnt,
   input logic               ack_seen
);
   AST_RETX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      retx_out |=> !retx_out); // R3
   AST_RETX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      retx_out |-> $past(conn_done && !conn_ok && tx_active)); // R3
   AST_OWNER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && !$past(tx_active)) |-> (($past(rnd_a) ^ $past(rnd_b)) == UNIT_ID)); // R2 R5
   AST_CNT_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_cnt != $past(retry_cnt)) |-> ($past(retx_in) || retry_cnt == '0)); // R4
   AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      drop_out |-> ($past(op_abort) && $past(tx_active) && !tx_active)); // R9
   AST_LOG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_req |-> $past(conn_done)); // R7
   AST_FINAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_seen) |-> !tx_active); // R6 R8
endmodule

bind rrc_unit rrc_unit_chk #(.UNIT_ID(UNIT_ID), .RETRY_W(RETRY_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_start  (op_start),
   .op_abort  (op_abort),
   .rnd_a     (rnd_a),
   .rnd_b     (rnd_b),
   .retx_in   (retx_in),
   .retx_out  (retx_out),
   .conn_done (conn_done),
   .conn_ok   (conn_ok),
   .tx_active (tx_active),
   .drop_out  (drop_out),
   .st_wr_req (st_wr_req),
   .retry_cnt (retry_cnt),
   .ack_seen  (ack_seen)
);

// File: tb/tb_rrc_unit.sv
module tb_rrc_unit;
   localparam int unsigned RW = 4;
   localparam int unsigned PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 1'b0;
   logic          op_abort = 1'b0;
   logic [RW-1:0] lim = '0;
   logic          log_ok = 1'b0;
   logic [PW-1:0] base = '0;
   logic          rnd_a = 1'b0;
   logic          rnd_b = 1'b0;
   logic [1:0]    cd = '0;
   logic [1:0]    co = '0;
   logic [1:0]    retx;
   logic [1:0]    tx;
   logic [1:0]    drop;
   logic [1:0]    wreq;
   logic [1:0]    seen;
   logic [1:0]    good;
   logic [PW-1:0] waddr [2];
   logic [63:0]   wdata [2];
   logic [RW-1:0] cnt [2];
   logic          retx_line;

   int unsigned vectors = 0;
   int unsigned fails = 0;
   int unsigned cyc = 0;

   assign retx_line = retx[0] | retx[1];

   always #10 clk = ~clk;

   rrc_unit #(.UNIT_ID(1'b0), .RETRY_W(RW), .PTR_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_abort(op_abort),
      .cfg_retries(lim), .cfg_log_ok(log_ok), .cfg_status_base(base),
      .rnd_a(rnd_a), .rnd_b(rnd_b), .retx_in(retx_line), .retx_out(retx[0]),
      .conn_done(cd[0]), .conn_ok(co[0]), .tx_active(tx[0]), .drop_out(drop[0]),
      .st_wr_req(wreq[0]), .st_wr_addr(waddr[0]), .st_wr_data(wdata[0]),
      .retry_cnt(cnt[0]), .ack_seen(seen[0]), .ack_good(good[0]));

   rrc_unit #(.UNIT_ID(1'b1), .RETRY_W(RW), .PTR_W(PW)) dut_peer (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_abort(op_abort),
      .cfg_retries(lim), .cfg_log_ok(log_ok), .cfg_status_base(base),
      .rnd_a(rnd_a), .rnd_b(rnd_b), .retx_in(retx_line), .retx_out(retx[1]),
      .conn_done(cd[1]), .conn_ok(co[1]), .tx_active(tx[1]), .drop_out(drop[1]),
      .st_wr_req(wreq[1]), .st_wr_addr(waddr[1]), .st_wr_data(wdata[1]),
      .retry_cnt(cnt[1]), .ack_seen(seen[1]), .ack_good(good[1]));

   function automatic logic [63:0] exp_record(input logic ok, input logic unit,
                                              input int unsigned k);
      logic [63:0] r;
      r = '0;
      r[0] = ok;
      r[1] = unit;
      r[8 +: RW] = k[RW-1:0];
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one operation on the pair; mode 0 random outcome, 1 always fail, 2 always succeed
   task automatic run_op(input logic [RW-1:0] l, input logic lg, input int mode,
                         input bit do_abort);
      logic own;
      logic ok;
      @(negedge clk);
      base = PW'($urandom);
      lim = l;
      log_ok = lg;
      rnd_a = 1'($urandom);
      rnd_b = 1'($urandom);
      own = rnd_a ^ rnd_b;
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
      check("R2 owner tx", {62'd0, tx}, own ? 64'd2 : 64'd1);
      check("R10 ack_seen cleared", {62'd0, seen}, 64'd0);
      check("R10 counts loaded", {56'd0, cnt[0], cnt[1]}, 64'd0);
      if (do_abort) begin
         op_abort = 1'b1;
         @(negedge clk);
         op_abort = 1'b0;
         check("R9 drop only on owner", {62'd0, drop}, own ? 64'd2 : 64'd1);
         check("R9 tx cleared", {62'd0, tx}, 64'd0);
         @(negedge clk);
         check("R9 drop one cycle", {62'd0, drop}, 64'd0);
         return;
      end
      for (int unsigned k = 0; k < 64; k++) begin
         ok = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : (($urandom % 3) == 0);
         cd[own] = 1'b1;
         co[own] = ok;
         @(negedge clk);
         cd = '0;
         co = '0;
         check(ok ? "R8 log gating" : "R7 log on fail", wreq[own], (!ok || lg) ? 64'd1 : 64'd0);
         check("R7 no log from peer", wreq[!own], 64'd0);
         if (!ok || lg) begin
            check("R7 record addr", waddr[own], PW'(base + PW'(k)));
            check("R7 record data", wdata[own], exp_record(ok, own, k));
         end
         if (ok) begin
            check("R8 ack pair", {62'd0, seen[own], good[own]}, 64'd3);
            check("R8 tx cleared", {62'd0, tx}, 64'd0);
            break;
         end
         if (k == int'(l)) begin
            check("R6 exhausted ack pair", {62'd0, seen[own], good[own]}, 64'd2);
            check("R6 no retransmit", {62'd0, retx}, 64'd0);
            check("R6 idle", {62'd0, tx}, 64'd0);
            break;
         end
         check("R3 retransmit from owner", {62'd0, retx}, own ? 64'd2 : 64'd1);
         check("R3 tx dropped", {62'd0, tx}, 64'd0);
         rnd_a = 1'($urandom);
         rnd_b = 1'($urandom);
         own = rnd_a ^ rnd_b;
         @(negedge clk);
         check("R3 retransmit pulse ends", {62'd0, retx}, 64'd0);
         check("R4 counts step together", {56'd0, cnt[0], cnt[1]},
               {56'd0, RW'(k + 1), RW'(k + 1)});
         @(negedge clk);
         check("R5 reselected owner", {62'd0, tx}, own ? 64'd2 : 64'd1);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL R1 watchdog expired: actual %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset idle outputs",
            {52'd0, tx, retx, drop, wreq, seen, good}, 64'd0);
      check("R1 reset counts", {56'd0, cnt[0], cnt[1]}, 64'd0);
      run_op(4'd0, 1'b0, 1, 1'b0);   // zero limit, single failure
      run_op(4'd3, 1'b0, 1, 1'b0);   // run to the limit
      run_op(4'd2, 1'b1, 2, 1'b0);   // success logged
      run_op(4'd2, 1'b0, 2, 1'b0);   // success not logged
      run_op(4'd5, 1'b0, 0, 1'b1);   // abort while transmitting
      // abort while the other unit owns: only that unit may drop
      run_op(4'd5, 1'b1, 0, 1'b1);
      for (int i = 0; i < 60; i++) begin
         run_op(RW'($urandom), 1'($urandom), 0, (($urandom % 10) == 0));
      end
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule